// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Channel with Request/Clear-to-Send Handshake

This block is one asynchronous serial channel with a transmitter and a receiver that run at the same time on separate lines. The host hands characters to the transmitter over a valid/ready stream, and the transmitter sends them as frames on `txd`. Each frame is one low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one high stop bit. The line idles high. The receiver takes frames from `rxd` into a four-entry queue. The host drains that queue through a second valid/ready stream. Each queued character carries its own parity-error and framing-error flags.

Flow control is done in hardware. `rts_n` is low whenever the queue has room for another character. The transmitter starts a frame only while `cts_n` is low. In echo mode the queue is drained by the transmitter instead of the host, so every received character goes back out on `txd` in arrival order.

Rates are set from outside with two enable pulses. `tx_tick` marks each transmit bit boundary. `rx_tick` runs at 16 times the receive bit rate. The two are independent, so the two directions may run at different rates.

Back-pressure rules:
- The input stream hands over a character on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in a `tx_tick` cycle while the transmitter is idle, `cts_n` is low and echo mode is off.
- The output stream pops the head of the queue on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head and its flags stay where they are.

Top module: `uart_flow_chan`

## Requirements
- R1: After reset, `txd` is high, `rts_n` is low, `out_valid` is low and `overrun` is low.
- R2: A frame on `txd` is a low start bit, then the data bits least significant bit first, then the optional parity bit, then a high stop bit. Each bit lasts one `tx_tick` period. The number of data bits is 5 + `cfg_len` (codes 0..3 give 5..8 bits). Host data bits above that length are not sent. A character looped from `txd` to `rxd` comes out of the queue unchanged.
- R3: The queue holds up to 4 characters. `rts_n` is high while 4 are held and low otherwise.
- R4: A character that completes while the queue is full is discarded, and the 4 queued characters are not changed. `overrun` is set at that point and stays high until reset.
- R5: With `cfg_par_en` = 1, a parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. The sent bit makes the count of ones over the data and parity bits even (or odd). On receive, `out_perr` is high for a head character whose parity bit is wrong.
- R6: `out_ferr` is high for a head character whose stop bit was sampled low. After such a frame the receiver waits for the line to return high before it looks for a new start bit, so a later good frame is received correctly.
- R7: While `cts_n` is high, no character is accepted, `in_ready` stays low and `txd` stays high. Once `cts_n` goes low, the pending character is sent.
- R8: With `cfg_echo` = 1, each received character is retransmitted on `txd` with the current format, `out_valid` stays low and `in_ready` stays low.
- R9: `out_data` and `out_valid` hold steady while `out_ready` is low. Pops return characters in the order they arrived.
- R10: A low pulse on `rxd` shorter than half a bit time is rejected at the start-bit midpoint and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tick | input | 1 | Transmit bit-rate enable pulse |
| rx_tick | input | 1 | Receive 16x oversample enable pulse |
| cfg_len | input | 2 | Data-bit count minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_echo | input | 1 | Echo received characters back on txd |
| in_valid | input | 1 | Host character offered |
| in_ready | output | 1 | Transmitter takes the character this cycle |
| in_data | input | 8 | Host character |
| out_valid | output | 1 | Queue head available to the host |
| out_ready | input | 1 | Host pops the queue head |
| out_data | output | 8 | Queue head character, right-aligned |
| out_perr | output | 1 | Parity error flag of the queue head |
| out_ferr | output | 1 | Framing error flag of the queue head |
| overrun | output | 1 | Sticky flag for a character lost to a full queue |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Active-low ready-to-receive |
| cts_n | input | 1 | Active-low clear-to-send |

## Verification
The bench uses the default parameters: a four-entry queue and 16x oversampling. It drives `rx_tick` every 2 clocks and `tx_tick` every 32 clocks, so the transmit and receive bit times match and a frame takes only a few hundred cycles. At that speed the bench can fill the queue up to the overrun point and run all four character lengths, both parity senses, loopback, echo and framing-error frames well inside the cycle budget. A bench-side line driver with its own bit timing makes bad parity, low stop bits and short glitches that a correct transmitter never sends.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;

endpackage

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_flow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cts_n,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  output logic              src_ready,
  output logic              txd,
  output logic              busy
);
  localparam int IDX_W = $clog2(CHAR_W);

  tx_state_e         st;
  logic [IDX_W-1:0]  idx, last_q, last_in;
  logic [CHAR_W-1:0] sh, mask, masked;
  logic              pbit, par_q, take;

  assign last_in   = IDX_W'(len_code) + IDX_W'(CHAR_W - 4);
  assign src_ready = (st == TX_IDLE) && tick && !cts_n;
  assign take      = src_ready && src_valid;
  assign busy      = (st != TX_IDLE);
  assign masked    = src_data & mask;

  always_comb begin
    for (int i = 0; i < CHAR_W; i++) mask[i] = (i <= int'(last_in));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      sh     <= '0;
      idx    <= '0;
      last_q <= '0;
      pbit   <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (take) begin
          sh     <= masked;
          pbit   <= (^masked) ^ par_odd;
          par_q  <= par_en;
          last_q <= last_in;
          idx    <= '0;
          st     <= TX_START;
        end
        TX_START: if (tick) st <= TX_DATA;
        TX_DATA: if (tick) begin
          sh <= sh >> 1;
          if (idx == last_q) st <= par_q ? TX_PAR : TX_STOP;
          else idx <= idx + 1'b1;
        end
        TX_PAR:  if (tick) st <= TX_STOP;
        TX_STOP: if (tick) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh[0];
      TX_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_flow_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       char_valid,
  output rx_char_t   char_out
);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e         st;
  logic [1:0]        sync;
  logic              rx_s, pr, par_q, odd_q, bit_end;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx, last_q;
  logic [CHAR_W-1:0] sh, aligned;

  assign rx_s    = sync[1];
  assign bit_end = tick && (cnt == LAST);
  assign aligned = sh >> (IDX_W'(CHAR_W - 1) - last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      last_q     <= '0;
      sh         <= '0;
      pr         <= 1'b0;
      par_q      <= 1'b0;
      odd_q      <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (tick && st != RX_IDLE && st != RX_HOLD) cnt <= cnt + 1'b1;
      case (st)
        RX_IDLE: if (tick && !rx_s) begin
          st     <= RX_START;
          cnt    <= '0;
          last_q <= IDX_W'(len_code) + IDX_W'(CHAR_W - 4);
          par_q  <= par_en;
          odd_q  <= par_odd;
        end
        RX_START: if (tick && cnt == MID) begin
          cnt <= '0;
          idx <= '0;
          st  <= rx_s ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (bit_end) begin
          cnt <= '0;
          sh  <= {rx_s, sh[CHAR_W-1:1]};
          if (idx == last_q) st <= par_q ? RX_PAR : RX_STOP;
          else idx <= idx + 1'b1;
        end
        RX_PAR: if (bit_end) begin
          cnt <= '0;
          pr  <= rx_s;
          st  <= RX_STOP;
        end
        RX_STOP: if (bit_end) begin
          cnt           <= '0;
          char_valid    <= 1'b1;
          char_out.data <= aligned;
          char_out.perr <= par_q && (pr != ((^aligned) ^ odd_q));
          char_out.ferr <= !rx_s;
          st            <= rx_s ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: if (rx_s) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_flow_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  rx_char_t                   wr_char,
  input  logic                       rd_pop,
  output rx_char_t                   head,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, do_wr, do_rd;

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign do_wr     = wr_valid && !full;
  assign do_rd     = rd_pop && not_empty;
  assign head      = mem[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (do_wr && wptr == PTR_W'(g))       mem[g] <= wr_char;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_valid && full) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_flow_chan.sv
module uart_flow_chan
  import uart_flow_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_tick,
  input  logic              rx_tick,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_echo,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              overrun,
  output logic              txd,
  input  logic              rxd,
  output logic              rts_n,
  input  logic              cts_n
);
  localparam int QCNT_W = $clog2(QDEPTH + 1);

  rx_char_t            rx_char, q_head;
  logic                rx_valid, q_avail, q_pop;
  logic [QCNT_W-1:0]   q_count;
  logic                tx_busy, tx_ready, tx_src_valid, tx_take;
  logic [CHAR_W-1:0]   tx_src_data;

  assign tx_src_valid = cfg_echo ? q_avail : in_valid;
  assign tx_src_data  = cfg_echo ? q_head.data : in_data;
  assign tx_take      = tx_ready && tx_src_valid;
  assign in_ready     = tx_ready && !cfg_echo;

  assign out_valid = q_avail && !cfg_echo;
  assign out_data  = q_head.data;
  assign out_perr  = q_head.perr;
  assign out_ferr  = q_head.ferr;
  assign q_pop     = cfg_echo ? tx_take : (out_valid && out_ready);
  assign rts_n     = (q_count == QCNT_W'(QDEPTH));

  uart_tx_ser i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tx_tick),
    .cts_n     (cts_n),
    .len_code  (cfg_len),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .src_valid (tx_src_valid),
    .src_data  (tx_src_data),
    .src_ready (tx_ready),
    .txd       (txd),
    .busy      (tx_busy)
  );

  uart_rx_deser #(.OVS(OVS)) i_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (rx_tick),
    .rxd        (rxd),
    .len_code   (cfg_len),
    .par_en     (cfg_par_en),
    .par_odd    (cfg_par_odd),
    .char_valid (rx_valid),
    .char_out   (rx_char)
  );

  uart_rx_queue #(.DEPTH(QDEPTH)) i_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (rx_valid),
    .wr_char   (rx_char),
    .rd_pop    (q_pop),
    .head      (q_head),
    .not_empty (q_avail),
    .count     (q_count),
    .ovr       (overrun)
  );
endmodule

// File: rtl/uart_flow_chan_chk.sv
module uart_flow_chan_chk #(
  parameter int QDEPTH = 4,
  parameter int QCNT_W = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cts_n,
  input logic              rts_n,
  input logic              cfg_echo,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              overrun,
  input logic              tx_busy,
  input logic [QCNT_W-1:0] q_count
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCNT_W'(QDEPTH));

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!cts_n));

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_ovr_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rts_n));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (cfg_echo || (out_valid && $stable(out_data))));
endmodule

bind uart_flow_chan uart_flow_chan_chk #(.QDEPTH(QDEPTH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cts_n     (cts_n),
  .rts_n     (rts_n),
  .cfg_echo  (cfg_echo),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .overrun   (overrun),
  .tx_busy   (tx_busy),
  .q_count   (q_count)
);

// File: tb/test_uart_flow_chan.sv
module test_uart_flow_chan;
  localparam int BIT = 32;
  // {len code, parity enable, odd, data}
  localparam logic [11:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5}, {2'd3, 1'b1, 1'b0, 8'h3C},
    {2'd3, 1'b1, 1'b1, 8'h3C}, {2'd0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b0, 8'hE7}, {2'd2, 1'b1, 1'b1, 8'h80},
    {2'd2, 1'b0, 1'b0, 8'h55}, {2'd0, 1'b1, 1'b1, 8'h0B}
  };

  logic clk = 0, rst_n = 0, tx_tick = 0, rx_tick = 0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_echo = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0] in_data = 0, out_data;
  logic out_perr, out_ferr, overrun, txd, rxd, rts_n, cts_n = 0;
  logic loop_sel = 1, drv = 1;
  int n_chk = 0, n_fail = 0;
  int unsigned tc = 0;

  assign rxd = loop_sel ? txd : drv;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    rx_tick = (tc % 2 == 0);
    tx_tick = (tc % BIT == 0);
    tc++;
  end

  uart_flow_chan i_uart_flow_chan (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_echo(cfg_echo), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
    .overrun(overrun), .txd(txd), .rxd(rxd), .rts_n(rts_n), .cts_n(cts_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_send(input logic [7:0] d);
    in_data  = d;
    in_valid = 1;
    do begin @(negedge clk); #1; end while (!in_ready);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic cap_tx(output logic [7:0] d, output logic p, output logic stopb,
                        output logic startok, input int nb, input bit pe);
    d = '0; p = 0;
    do @(negedge clk); while (txd);
    repeat (BIT/2) @(negedge clk);
    startok = !txd;
    for (int i = 0; i < nb; i++) begin repeat (BIT) @(negedge clk); d[i] = txd; end
    if (pe) begin repeat (BIT) @(negedge clk); p = txd; end
    repeat (BIT) @(negedge clk);
    stopb = txd;
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nb, input bit pe,
                             input logic pb, input logic stopv);
    @(negedge clk); drv = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (BIT) @(negedge clk); end
    if (pe) begin drv = pb; repeat (BIT) @(negedge clk); end
    drv = stopv; repeat (BIT) @(negedge clk);
    drv = 1; repeat (BIT) @(negedge clk);
  endtask

  task automatic wait_out(output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1; break; end
    end
  endtask

  task automatic pop();
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] cd, ex, msk;
    logic cp, cs, cst, ep;
    bit got, bad;
    int nb;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1, "R1", "txd idle", txd, 1);
    chk(rts_n == 0, "R1", "rts_n", rts_n, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(overrun == 0, "R1", "overrun", overrun, 0);

    // R2 / R5: table of formats, checked on txd and through loopback
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cfg_len = VEC[v][11:10]; cfg_par_en = VEC[v][9]; cfg_par_odd = VEC[v][8];
      nb  = 5 + int'(VEC[v][11:10]);
      msk = 8'((1 << nb) - 1);
      ex  = VEC[v][7:0] & msk;
      ep  = (^ex) ^ VEC[v][8];
      fork
        host_send(VEC[v][7:0]);
        cap_tx(cd, cp, cs, cst, nb, VEC[v][9]);
      join
      chk(cst && cs && cd == ex, "R2", "txd frame bits", {cst, cs, cd}, {2'b11, ex});
      if (VEC[v][9]) chk(cp == ep, "R5", "txd parity bit", cp, ep);
      wait_out(got);
      chk(got && out_data == ex && !out_perr && !out_ferr, "R2", "loopback char",
          {got, out_perr, out_ferr, out_data}, {3'b100, ex});
      pop();
    end

    // R7 clear-to-send gate
    @(negedge clk);
    cfg_len = 2'd3; cfg_par_en = 0; cfg_par_odd = 0;
    cts_n = 1; in_data = 8'h42; in_valid = 1; bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (in_ready || !txd) bad = 1;
    end
    chk(!bad, "R7", "held while cts_n high", bad, 0);
    cts_n = 0;
    fork
      host_send(8'h42);
      cap_tx(cd, cp, cs, cst, 8, 0);
    join
    chk(cst && cs && cd == 8'h42, "R7", "sent after cts_n low", cd, 8'h42);
    wait_out(got);
    pop();

    // R10 short glitch rejected
    loop_sel = 0;
    @(negedge clk); drv = 0;
    repeat (4) @(negedge clk);
    drv = 1;
    repeat (600) @(negedge clk);
    chk(out_valid == 0, "R10", "glitch produced no char", out_valid, 0);

    // R5 parity error flagged, even parity, 0x5A needs parity bit 0
    cfg_par_en = 1; cfg_par_odd = 0;
    drive_frame(8'h5A, 8, 1, 1'b1, 1'b1);
    wait_out(got);
    chk(got && out_data == 8'h5A && out_perr, "R5", "bad parity flagged",
        {out_perr, out_data}, {1'b1, 8'h5A});
    pop();
    drive_frame(8'h5A, 8, 1, 1'b0, 1'b1);
    wait_out(got);
    chk(got && !out_perr, "R5", "good parity clean", out_perr, 0);
    pop();

    // R6 framing error, then recovery
    cfg_par_en = 0;
    drive_frame(8'h33, 8, 0, 1'b0, 1'b0);
    wait_out(got);
    chk(got && out_data == 8'h33 && out_ferr, "R6", "low stop flagged",
        {out_ferr, out_data}, {1'b1, 8'h33});
    pop();
    drive_frame(8'h77, 8, 0, 1'b0, 1'b1);
    wait_out(got);
    chk(got && out_data == 8'h77 && !out_ferr, "R6", "recovered frame",
        {out_ferr, out_data}, {1'b0, 8'h77});
    pop();

    // R3 / R4 / R9 fill past the queue depth
    for (int i = 0; i < 4; i++) drive_frame(8'h10 + 8'(i), 8, 0, 1'b0, 1'b1);
    chk(rts_n == 1 && overrun == 0, "R3", "full queue raises rts_n",
        {rts_n, overrun}, 2'b10);
    drive_frame(8'h14, 8, 0, 1'b0, 1'b1);
    chk(overrun == 1, "R4", "overrun set", overrun, 1);
    repeat (50) @(negedge clk);
    chk(out_valid && out_data == 8'h10, "R9", "head held under back-pressure",
        out_data, 8'h10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 8'h10 + 8'(i), "R9", "pop order", out_data,
          8'h10 + 8'(i));
      pop();
      if (i == 0) chk(rts_n == 0, "R3", "rts_n low after pop", rts_n, 0);
    end
    @(negedge clk);
    chk(out_valid == 0, "R4", "fifth char discarded", out_valid, 0);
    chk(overrun == 1, "R4", "overrun sticky", overrun, 1);

    // R8 echo mode
    cfg_echo = 1; in_data = 8'h99; in_valid = 1; bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (in_ready) bad = 1;
    end
    in_valid = 0;
    chk(!bad, "R8", "host input blocked in echo", bad, 0);
    fork
      drive_frame(8'hC9, 8, 0, 1'b0, 1'b1);
      cap_tx(cd, cp, cs, cst, 8, 0);
    join
    chk(cst && cs && cd == 8'hC9, "R8", "echoed frame", cd, 8'hC9);
    repeat (40) @(negedge clk);
    chk(out_valid == 0, "R8", "echoed char not offered to host", out_valid, 0);
    cfg_echo = 0;

    // R1 / R4 reset clears overrun
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(overrun == 0 && rts_n == 0, "R4", "reset clears overrun",
        {overrun, rts_n}, 2'b00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule